// File: doc/BRIEF.md
# Handshaked Memory-DMA Request Pacer

This block lets an external block-buffered or FIFO-style device pace one memory-to-memory DMA channel through a single request pin. The pin is brought into the clock domain through a synchronizer. Each rising edge found on it credits a programmable number of transfers to an outstanding-grant counter. A control bit chooses whether the credit paces the read (source) side or the write (destination) side of the channel. Each transfer the DMA engine completes on the paced side spends one credit. While no credit is left, the paced side is held off and the other side runs freely.

The counter can also raise an urgency flag toward the external bus arbiter. The flag is raised when enough work is outstanding and the boost option is on, so that the memory DMA is served ahead of core traffic. When the pacer is disabled, the counter and its sticky overflow flag are cleared and both sides of the channel run unpaced.

Top module: `dma_pace_ctrl`

## Requirements
- R1: After reset the outstanding count is 0, both go outputs are 1, urgent is 0 and the overflow flag is 0. The control register resets to 0 (disabled), the step register to 1 and the threshold register to 0.
- R2: A 0-to-1 transition of req_pin, held for at least two clocks, raises the outstanding count by the step register value. The new count is visible after the third rising clock edge that follows the pin change. Keeping the pin high or letting it fall adds nothing.
- R3: With control bit 1 at 0 the source side is paced: src_go is 0 exactly when the pacer is enabled and the count is 0, and dst_go stays 1. With bit 1 at 1 the roles of src_go and dst_go swap.
- R4: A completion pulse on the paced side's done input lowers the count by one. A pulse on the other side's done input is ignored, and so is a pulse on the paced side while the count is 0.
- R5: When a credited edge and a paced-side completion take effect on the same clock edge, the count changes by the step value minus one.
- R6: urgent is 1 exactly when control bit 0 (enable) and bit 2 (boost) are both set and the count is strictly greater than the threshold register.
- R7: A credit that would take the count above 65535 leaves the count at 65535 and sets ovf_flag. The flag stays set while the pacer remains enabled, even after the count falls.
- R8: With control bit 0 at 0, the count and ovf_flag are 0 one clock later, both go outputs are 1, and request edges add nothing.
- R9: A write with cfg_we=1 stores cfg_wdata in the register at cfg_addr and takes effect from the next clock edge. Address 0 is control (bit 0 enable, bit 1 destination-side select, bit 2 boost), address 1 is the per-edge step and address 2 is the urgency threshold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_pin | input | 1 | Asynchronous request from the external device |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | Configuration register address |
| cfg_wdata | input | 16 | Configuration write data |
| src_done | input | 1 | One source-side transfer completed |
| dst_done | input | 1 | One destination-side transfer completed |
| src_go | output | 1 | Source side may issue a transfer |
| dst_go | output | 1 | Destination side may issue a transfer |
| urgent | output | 1 | Raise DMA priority on the external bus |
| owed_cnt | output | 16 | Outstanding granted transfers |
| ovf_flag | output | 1 | Sticky: a credit was clipped at the maximum |

## Verification
Two events can land on the counter at the same clock edge: the credit from a synchronized request edge and the debit from a paced-side completion. The bench provokes this on purpose. It raises the pin, waits two clocks and then pulses the paced done input, so that both updates meet on the third edge. The count must then move by exactly the step minus one. The same coincidence is provoked when the count sits at its ceiling and when it is zero, and many more cases arise from the random mix. Every cycle, all outputs are compared against a bench model that applies both updates in one step.

// File: rtl/dma_pace_pkg.sv
package dma_pace_pkg;
   localparam int CFG_AW = 2;

   typedef struct packed {
      logic boost;
      logic dst_side;
      logic en;
   } pace_ctrl_t;

   localparam logic [CFG_AW-1:0] ADDR_CTRL = 2'd0;
   localparam logic [CFG_AW-1:0] ADDR_STEP = 2'd1;
   localparam logic [CFG_AW-1:0] ADDR_THR  = 2'd2;
endpackage

// File: rtl/pace_req_sync.sv
module pace_req_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin,
   output logic rise
);
   localparam int CHAIN_W = STAGES + 1;

   if (STAGES < 2) begin : g_bad_stages
      $error("pace_req_sync: STAGES must be at least 2");
   end

   logic [CHAIN_W-1:0] chain;

   always_ff @(posedge clk) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[CHAIN_W-2:0], pin};
   end

   assign rise = chain[STAGES-1] & ~chain[STAGES];

   // R2
   single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rise |=> !rise);
endmodule

// File: rtl/pace_grant_ctr.sv
module pace_grant_ctr #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         en,
   input  logic         add_ev,
   input  logic [W-1:0] step,
   input  logic         take,
   output logic [W-1:0] cnt,
   output logic         ovf
);
   localparam logic [W-1:0] MAXV = {W{1'b1}};

   if (W < 2) begin : g_bad_width
      $error("pace_grant_ctr: W must be at least 2");
   end

   logic         dec;
   logic [W:0]   add_val;
   logic [W:0]   sum;

   assign dec     = take && (cnt != '0);
   assign add_val = add_ev ? {1'b0, step} : '0;
   assign sum     = {1'b0, cnt} + add_val - {{W{1'b0}}, dec};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt <= '0;
         ovf <= 1'b0;
      end else if (!en) begin
         cnt <= '0;
         ovf <= 1'b0;
      end else if (sum[W]) begin
         cnt <= MAXV;
         ovf <= 1'b1;
      end else begin
         cnt <= sum[W-1:0];
      end
   end

   // R4
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en && cnt == '0 && !add_ev) |=> cnt == '0);
   // R7
   sat_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ovf) |-> cnt == MAXV);
   // R8
   clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> (cnt == '0 && !ovf));
endmodule

// File: rtl/pace_urgency.sv
module pace_urgency #(
   parameter int W       = 16,
   parameter bit REG_OUT = 1'b0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         en,
   input  logic         boost,
   input  logic [W-1:0] cnt,
   input  logic [W-1:0] thr,
   output logic         urgent
);
   logic hot;
   assign hot = en && boost && (cnt > thr);

   if (REG_OUT) begin : g_reg
      always_ff @(posedge clk) begin
         if (!rst_n) urgent <= 1'b0;
         else        urgent <= hot;
      end
   end else begin : g_comb
      assign urgent = hot;
      // R6
      urg_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
         urgent |-> cnt != '0);
   end
endmodule

// File: rtl/dma_pace_ctrl.sv
module dma_pace_ctrl
   import dma_pace_pkg::*;
#(
   parameter int          CNT_W       = 16,
   parameter int          SYNC_STAGES = 2,
   parameter bit          URG_REG     = 1'b0,
   parameter int unsigned STEP_RST    = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_pin,
   input  logic              cfg_we,
   input  logic [CFG_AW-1:0] cfg_addr,
   input  logic [CNT_W-1:0]  cfg_wdata,
   input  logic              src_done,
   input  logic              dst_done,
   output logic              src_go,
   output logic              dst_go,
   output logic              urgent,
   output logic [CNT_W-1:0]  owed_cnt,
   output logic              ovf_flag
);
   localparam int CTRL_W = $bits(pace_ctrl_t);

   if (CNT_W < CTRL_W || CNT_W > 32) begin : g_bad_cnt
      $error("dma_pace_ctrl: CNT_W out of range");
   end

   pace_ctrl_t       ctrl_q;
   logic [CNT_W-1:0] step_q;
   logic [CNT_W-1:0] thr_q;
   logic             rise;
   logic             take;
   logic             starve;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl_q <= '0;
         step_q <= CNT_W'(STEP_RST);
         thr_q  <= '0;
      end else if (cfg_we) begin
         case (cfg_addr)
            ADDR_CTRL: ctrl_q <= pace_ctrl_t'(cfg_wdata[CTRL_W-1:0]);
            ADDR_STEP: step_q <= cfg_wdata;
            ADDR_THR:  thr_q  <= cfg_wdata;
            default:   ;
         endcase
      end
   end

   pace_req_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .pin  (req_pin),
      .rise (rise)
   );

   assign take = ctrl_q.dst_side ? dst_done : src_done;

   pace_grant_ctr #(.W(CNT_W)) u_ctr (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (ctrl_q.en),
      .add_ev(rise),
      .step  (step_q),
      .take  (take),
      .cnt   (owed_cnt),
      .ovf   (ovf_flag)
   );

   pace_urgency #(.W(CNT_W), .REG_OUT(URG_REG)) u_urg (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (ctrl_q.en),
      .boost (ctrl_q.boost),
      .cnt   (owed_cnt),
      .thr   (thr_q),
      .urgent(urgent)
   );

   assign starve = ctrl_q.en && (owed_cnt == '0);
   assign src_go = !(starve && !ctrl_q.dst_side);
   assign dst_go = !(starve &&  ctrl_q.dst_side);

   // R3
   stall_needs_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!src_go || !dst_go) |-> (owed_cnt == '0 && ctrl_q.en));
   // R3
   one_side_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (src_go || dst_go));
endmodule

// File: tb/sim_dma_pace_ctrl.sv
module sim_dma_pace_ctrl;
   localparam int CLK_PERIOD = 10;
   localparam int MAXV = 65535;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_pin = 1'b0;
   logic        cfg_we = 1'b0;
   logic [1:0]  cfg_addr = 2'd0;
   logic [15:0] cfg_wdata = 16'd0;
   logic        src_done = 1'b0;
   logic        dst_done = 1'b0;
   logic        src_go, dst_go, urgent, ovf_flag;
   logic [15:0] owed_cnt;

   int n_cmp = 0;
   int n_bad = 0;

   int m_cnt = 0, m_pe = 1, m_thr = 0;
   bit m_ovf = 0, m_en = 0, m_side = 0, m_boost = 0;
   bit ph1 = 0, ph2 = 0, ph3 = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   dma_pace_ctrl u0 (
      .clk(clk), .rst_n(rst_n), .req_pin(req_pin),
      .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
      .src_done(src_done), .dst_done(dst_done),
      .src_go(src_go), .dst_go(dst_go), .urgent(urgent),
      .owed_cnt(owed_cnt), .ovf_flag(ovf_flag)
   );

   function automatic bit exp_src_go();
      return !m_en || m_side || (m_cnt != 0);
   endfunction
   function automatic bit exp_dst_go();
      return !m_en || !m_side || (m_cnt != 0);
   endfunction
   function automatic bit exp_urgent();
      return m_en && m_boost && (m_cnt > m_thr);
   endfunction

   task automatic model_edge();
      bit rise_now;
      bit took;
      int sum;
      rise_now = ph2 && !ph3;
      ph3 = ph2; ph2 = ph1; ph1 = req_pin;
      if (!m_en) begin
         m_cnt = 0; m_ovf = 0;
      end else begin
         took = (m_side ? dst_done : src_done) && (m_cnt != 0);
         sum = m_cnt + (rise_now ? m_pe : 0) - (took ? 1 : 0);
         if (sum > MAXV) begin m_cnt = MAXV; m_ovf = 1; end
         else m_cnt = sum;
      end
      if (cfg_we) begin
         case (cfg_addr)
            2'd0: begin m_en = cfg_wdata[0]; m_side = cfg_wdata[1]; m_boost = cfg_wdata[2]; end
            2'd1: m_pe = cfg_wdata;
            2'd2: m_thr = cfg_wdata;
            default: ;
         endcase
      end
   endtask

   task automatic compare(string tag);
      n_cmp++;
      if (owed_cnt !== 16'(m_cnt) || src_go !== exp_src_go() || dst_go !== exp_dst_go()
          || urgent !== exp_urgent() || ovf_flag !== m_ovf) begin
         n_bad++;
         $display("FAIL %s: cnt=%0d exp %0d src_go=%b exp %b dst_go=%b exp %b urgent=%b exp %b ovf=%b exp %b",
                  tag, owed_cnt, m_cnt, src_go, exp_src_go(), dst_go, exp_dst_go(),
                  urgent, exp_urgent(), ovf_flag, m_ovf);
      end
   endtask

   task automatic tick(string tag);
      @(posedge clk);
      model_edge();
      @(negedge clk);
      compare(tag);
      cfg_we = 0; src_done = 0; dst_done = 0;
   endtask

   task automatic wcfg(logic [1:0] a, logic [15:0] d, string tag);
      cfg_we = 1; cfg_addr = a; cfg_wdata = d;
      tick(tag);
   endtask

   task automatic edge_pin(string tag);
      req_pin = 1;
      repeat (3) tick(tag);
      req_pin = 0;
      repeat (2) tick(tag);
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      n_bad++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      void'($urandom(32'd4242));
      repeat (3) @(negedge clk);
      compare("R1 reset state");
      rst_n = 1;
      tick("R1 after release");

      // R9: program step 3, threshold 4, enable+source side+boost
      wcfg(2'd1, 16'd3, "R9 step write");
      wcfg(2'd2, 16'd4, "R9 threshold write");
      tick("R3 disabled gates open");
      wcfg(2'd0, 16'h0005, "R9 ctrl write");
      tick("R3 source starved at zero");

      // R2 latency, held level and falling edge
      req_pin = 1;
      tick("R2 edge latency 1");
      tick("R2 edge latency 2");
      tick("R2 edge latency 3");
      repeat (4) tick("R2 held level adds nothing");
      req_pin = 0;
      repeat (4) tick("R2 falling edge adds nothing");
      edge_pin("R6 above threshold");

      // R4 decrements on paced side only
      dst_done = 1; tick("R4 other side ignored");
      repeat (6) begin src_done = 1; tick("R4 paced side decrement"); end
      src_done = 1; tick("R4 done at zero ignored");
      tick("R3 source stalled");

      // R5 coincidence with a nonzero count
      edge_pin("R5 preload");
      req_pin = 1; tick("R5 setup"); tick("R5 setup");
      src_done = 1; tick("R5 credit and debit together");
      req_pin = 0; tick("R5 after");
      // R5 coincidence with a zero count
      repeat (8) begin src_done = 1; tick("R4 drain"); end
      req_pin = 1; tick("R5 setup zero"); tick("R5 setup zero");
      src_done = 1; tick("R5 coincide at zero");
      req_pin = 0; tick("R5 after zero");

      // R6 threshold boundary with step 1
      wcfg(2'd1, 16'd1, "R6 step 1");
      wcfg(2'd2, 16'd4, "R6 thr 4");
      repeat (3) edge_pin("R6 boundary climb");
      wcfg(2'd0, 16'h0001, "R6 boost off");
      edge_pin("R6 boost off no urgent");
      wcfg(2'd0, 16'h0005, "R6 boost on");
      tick("R6 boost on");

      // R3 destination side
      wcfg(2'd0, 16'h0007, "R3 dest select");
      repeat (20) begin dst_done = 1; tick("R3 dest drain"); end
      src_done = 1; tick("R3 source free in dest mode");
      edge_pin("R3 dest credit");

      // R7 saturation
      wcfg(2'd1, 16'hFFFF, "R7 big step");
      edge_pin("R7 saturate");
      edge_pin("R7 overflow sticky");
      req_pin = 1; tick("R7 sat coincide"); tick("R7 sat coincide");
      dst_done = 1; tick("R7 credit at ceiling with debit");
      req_pin = 0;
      repeat (3) begin dst_done = 1; tick("R7 flag survives decrement"); end

      // R8 disable
      wcfg(2'd0, 16'h0000, "R8 disable");
      tick("R8 cleared");
      edge_pin("R8 edges ignored");
      wcfg(2'd1, 16'd2, "R9 step 2");
      wcfg(2'd0, 16'h0001, "R8 re-enable");

      // random mix
      for (int i = 0; i < 4000; i++) begin
         int r;
         r = $urandom_range(0, 99);
         if (r < 25) req_pin = ~req_pin;
         src_done = ($urandom_range(0, 2) == 0);
         dst_done = ($urandom_range(0, 2) == 0);
         if ($urandom_range(0, 39) == 0) begin
            int a;
            a = $urandom_range(0, 3);
            cfg_we = 1; cfg_addr = 2'(a);
            case (a)
               0: cfg_wdata = 16'(($urandom_range(0, 9) == 0) ? $urandom_range(0, 7)
                                                              : ($urandom_range(0, 7) | 1));
               1: cfg_wdata = 16'($urandom_range(1, 8));
               2: cfg_wdata = 16'($urandom_range(0, 20));
               default: cfg_wdata = 16'($urandom_range(0, 65535));
            endcase
         end
         tick("R4 R5 random mix");
      end

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule